// File: doc/BRIEF.md
# Pinning-Aware RRIP Replacement for One Cache Set

This block holds the replacement state of a single 16-way set of a shared last-level cache and chooses the way a fill overwrites. Every way keeps a 2-bit re-reference prediction value (RRPV), a pin bit and a 2-bit producer/consumer state. One event arrives per cycle: read hit, read miss fill, write hit or write miss fill. Each event carries the hit way, the id of the issuing stream, a per-stream flag that marks streams with very high write-to-read reuse, the read-reuse band that an external estimator reports for texture reads, and a depth-write bypass choice made by an external dueling monitor.

The victim way and the bypass flag come out in the same cycle as a miss event. All state changes take effect at the next clock edge. Lines written by the render streams and then read by the texture sampler are tracked as dynamic texture. A read hit on such a line lowers its priority by an amount that depends on the reported band, so a likely final hit leaves the line close to eviction. Lines that write-heavy streams pin are skipped by the victim search. A pinned line that ages to the eviction value gets one more chance: it is released and restarts at RRPV 0.

Top module: `rrip_pin_set`

## Requirements
- R1: After a synchronous reset, every way has RRPV 3, is unpinned and is in state 00. With this state a read miss reports way 0 and no bypass.
- R2: The victim is the lowest-index unpinned way with RRPV 3. If no such way exists, a fill first ages the set by the number of steps that brings the highest unpinned RRPV to 3, and the victim is the lowest unpinned way that reaches 3.
- R3: A fill that is not bypassed writes RRPV 2 into the victim way. A read miss fill also leaves the way unpinned and in state 00.
- R4: Stream ids are CPU=0, shader=1, color=2, depth=3, blitter=4, texture=5, and 6 or 7 for other streams. A write miss from shader, color or blitter is allocated. A depth write miss is allocated only when depthBypass is 0. Every other write miss is bypassed.
- R5: A write hit sets RRPV 0. A write hit, or an allocated write miss, also pins the line when wrHigh[streamId] is 1. Pinned ways are never reported as victims.
- R6: When aging brings a pinned way to 3, its pin bit is cleared and its RRPV becomes 0. Any remaining aging steps of the same fill are then applied from 0.
- R7: A read hit clears the pin bit of the hit way. Unless R9 applies, it also sets the RRPV to 0.
- R8: Per-line state: a write hit or allocated write miss from color, depth or blitter sets 01. A texture read hit moves 01 to 10 and 10 or 11 to 11. A texture read hit on a line in state 00 leaves it at 00.
- R9: A texture read hit on a line whose state before the hit is not 00 sets the RRPV from rdBand: band 0 (below 1/64) gives 3, band 1 (1/64 up to 1/2) gives 2, and band 2 or 3 (1/2 and above) gives 0.
- R10: When all ways are pinned, any miss is bypassed and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | An event is present this cycle |
| evtType | input | 2 | 0 read hit, 1 read miss, 2 write hit, 3 write miss |
| hitWay | input | 4 | Way addressed by a hit event |
| streamId | input | 3 | Issuing stream (codes in R4) |
| wrHigh | input | 8 | Per-stream flag: write-to-read reuse is very high |
| depthBypass | input | 1 | Dueling choice: bypass depth write misses |
| rdBand | input | 2 | Read-reuse band for texture reads (R9) |
| victimWay | output | 4 | Way a fill overwrites this cycle |
| fillBypass | output | 1 | The current miss is not allocated |

## Verification
The bench builds the block with four ways and eight streams. With four ways, a few fills are enough to pin every way, to release pinned ways through multi-step aging, and to make a demoted texture line the next victim. The stimulus is chosen so that each band rule and each release is visible in a later victim choice: a wrong RRPV or pin bit leads to a different reported way or bypass value.

// File: rtl/rrip_pin_pkg.sv
package rrip_pin_pkg;

  typedef enum logic [1:0] {
    EV_RD_HIT  = 2'd0,
    EV_RD_MISS = 2'd1,
    EV_WR_HIT  = 2'd2,
    EV_WR_MISS = 2'd3
  } evt_e;

  localparam int SID_CPU     = 0;
  localparam int SID_SHADER  = 1;
  localparam int SID_COLOR   = 2;
  localparam int SID_DEPTH   = 3;
  localparam int SID_BLIT    = 4;
  localparam int SID_TEXTURE = 5;

  localparam logic [1:0] RRPV_FAR = 2'd3;
  localparam logic [1:0] RRPV_INS = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic       fill;
    logic       rdHit;
    logic       wrHit;
    logic       isWrite;
    logic       pinIt;
    logic       producer;
    logic       texRead;
    logic [1:0] bandRrpv;
  } strobe_t;

endpackage

// File: rtl/rrip_pin_ctrl.sv
module rrip_pin_ctrl
  import rrip_pin_pkg::*;
#(
  parameter int NSTREAMS = 8,
  localparam int SID_W = $clog2(NSTREAMS)
) (
  input  logic                evtValid,
  input  logic [1:0]          evtType,
  input  logic [SID_W-1:0]    streamId,
  input  logic [NSTREAMS-1:0] wrHigh,
  input  logic                depthBypass,
  input  logic [1:0]          rdBand,
  input  logic                allPinned,
  output strobe_t             strobe,
  output logic                fillBypass
);

  logic isMiss, isWrite, wrAlloc, policyBypass, producer;

  always_comb begin
    isMiss  = evtValid && (evtType == EV_RD_MISS || evtType == EV_WR_MISS);
    isWrite = (evtType == EV_WR_HIT || evtType == EV_WR_MISS);

    case (int'(streamId))
      SID_SHADER, SID_COLOR, SID_BLIT: wrAlloc = 1'b1;
      SID_DEPTH:                       wrAlloc = !depthBypass;
      default:                         wrAlloc = 1'b0;
    endcase

    case (int'(streamId))
      SID_COLOR, SID_DEPTH, SID_BLIT: producer = 1'b1;
      default:                        producer = 1'b0;
    endcase

    policyBypass = (evtType == EV_WR_MISS) && !wrAlloc;
    fillBypass   = isMiss && (allPinned || policyBypass);

    strobe.fill     = isMiss && !fillBypass;
    strobe.rdHit    = evtValid && (evtType == EV_RD_HIT);
    strobe.wrHit    = evtValid && (evtType == EV_WR_HIT);
    strobe.isWrite  = isWrite;
    strobe.pinIt    = isWrite && wrHigh[streamId];
    strobe.producer = producer;
    strobe.texRead  = (int'(streamId) == SID_TEXTURE);

    case (rdBand)
      2'd0:    strobe.bandRrpv = 2'd3;
      2'd1:    strobe.bandRrpv = 2'd2;
      default: strobe.bandRrpv = 2'd0;
    endcase
  end

endmodule

// File: rtl/rrip_pin_datapath.sv
module rrip_pin_datapath
  import rrip_pin_pkg::*;
#(
  parameter int WAYS = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [WAY_W-1:0]  hitWay,
  output logic [WAY_W-1:0]  victimWay,
  output logic              allPinned,
  output logic [2*WAYS-1:0] rrpvVec,
  output logic [WAYS-1:0]   pinVec
);

  logic [1:0] rrpvQ [WAYS];
  logic       pinQ  [WAYS];
  logic [1:0] stQ   [WAYS];

  logic [1:0] maxUnp, ageBy;
  logic       anyUnp, found;
  logic [2:0] ageSum   [WAYS];
  logic       releaseW [WAYS];
  logic [1:0] agedRrpv [WAYS];
  logic [1:0] hitSt, hitStNext, hitRrpv;

  // victim search and aging
  always_comb begin
    maxUnp    = 2'd0;
    anyUnp    = 1'b0;
    found     = 1'b0;
    victimWay = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!pinQ[i]) begin
        anyUnp = 1'b1;
        if (rrpvQ[i] > maxUnp) maxUnp = rrpvQ[i];
      end
    end
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !pinQ[i] && rrpvQ[i] == maxUnp) begin
        victimWay = WAY_W'(i);
        found     = 1'b1;
      end
    end
    allPinned = !anyUnp;
    ageBy     = RRPV_FAR - maxUnp;
    for (int i = 0; i < WAYS; i++) begin
      ageSum[i]   = {1'b0, rrpvQ[i]} + {1'b0, ageBy};
      releaseW[i] = pinQ[i] && (ageSum[i] >= 3'd3);
      agedRrpv[i] = releaseW[i] ? 2'(ageSum[i] - 3'd3) : ageSum[i][1:0];
    end
  end

  // hit-way state transitions
  always_comb begin
    hitSt = stQ[hitWay];
    if (strobe.texRead && hitSt != 2'b00)
      hitStNext = (hitSt == 2'b01) ? 2'b10 : 2'b11;
    else
      hitStNext = hitSt;
    hitRrpv = (strobe.texRead && hitSt != 2'b00) ? strobe.bandRrpv : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) begin
        rrpvQ[i] <= RRPV_FAR;
        pinQ[i]  <= 1'b0;
        stQ[i]   <= 2'b00;
      end
    end else begin
      if (strobe.fill) begin
        for (int i = 0; i < WAYS; i++) begin
          if (WAY_W'(i) == victimWay) begin
            rrpvQ[i] <= RRPV_INS;
            pinQ[i]  <= strobe.pinIt;
            stQ[i]   <= (strobe.isWrite && strobe.producer) ? 2'b01 : 2'b00;
          end else begin
            rrpvQ[i] <= agedRrpv[i];
            if (releaseW[i]) pinQ[i] <= 1'b0;
          end
        end
      end
      if (strobe.rdHit) begin
        pinQ[hitWay]  <= 1'b0;
        rrpvQ[hitWay] <= hitRrpv;
        stQ[hitWay]   <= hitStNext;
      end
      if (strobe.wrHit) begin
        rrpvQ[hitWay] <= 2'd0;
        if (strobe.pinIt)    pinQ[hitWay] <= 1'b1;
        if (strobe.producer) stQ[hitWay]  <= 2'b01;
      end
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_pack
    assign rrpvVec[2*g +: 2] = rrpvQ[g];
    assign pinVec[g]         = pinQ[g];
  end

endmodule

// File: rtl/rrip_pin_set.sv
module rrip_pin_set
  import rrip_pin_pkg::*;
#(
  parameter int WAYS     = 16,
  parameter int NSTREAMS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SID_W = $clog2(NSTREAMS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evtValid,
  input  logic [1:0]          evtType,
  input  logic [WAY_W-1:0]    hitWay,
  input  logic [SID_W-1:0]    streamId,
  input  logic [NSTREAMS-1:0] wrHigh,
  input  logic                depthBypass,
  input  logic [1:0]          rdBand,
  output logic [WAY_W-1:0]    victimWay,
  output logic                fillBypass
);

  strobe_t             strobe;
  logic                allPinned;
  logic [2*WAYS-1:0]   rrpvVec;
  logic [WAYS-1:0]     pinVec;

  rrip_pin_ctrl #(.NSTREAMS(NSTREAMS)) u_ctrl (
    .evtValid   (evtValid),
    .evtType    (evtType),
    .streamId   (streamId),
    .wrHigh     (wrHigh),
    .depthBypass(depthBypass),
    .rdBand     (rdBand),
    .allPinned  (allPinned),
    .strobe     (strobe),
    .fillBypass (fillBypass)
  );

  rrip_pin_datapath #(.WAYS(WAYS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .hitWay   (hitWay),
    .victimWay(victimWay),
    .allPinned(allPinned),
    .rrpvVec  (rrpvVec),
    .pinVec   (pinVec)
  );

endmodule

// File: rtl/rrip_pin_set_chk.sv
module rrip_pin_set_chk #(
  parameter int WAYS  = 16,
  parameter int WAY_W = 4,
  parameter int SID_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              evtValid,
  input logic [1:0]        evtType,
  input logic [WAY_W-1:0]  hitWay,
  input logic [SID_W-1:0]  streamId,
  input logic [WAY_W-1:0]  victimWay,
  input logic              fillBypass,
  input logic [2*WAYS-1:0] rrpvVec,
  input logic [WAYS-1:0]   pinVec
);

  logic [WAY_W-1:0] prevVictim, prevHit;
  logic             isFill;

  assign isFill = evtValid && (evtType == 2'd1 || evtType == 2'd3);

  always_ff @(posedge clk) begin
    prevVictim <= victimWay;
    prevHit    <= hitWay;
  end

  AST_VICTIM_UNPINNED: assert property (@(posedge clk) disable iff (rst)
    (isFill && !fillBypass) |-> !pinVec[victimWay]); // R5

  AST_FILL_INSERT: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtType == 2'd1 && !fillBypass) |=>
      (rrpvVec[2*prevVictim +: 2] == 2'd2 && !pinVec[prevVictim])); // R3

  AST_ALLPIN_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (isFill && (&pinVec)) |-> fillBypass); // R10

  AST_READHIT_UNPIN: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtType == 2'd0) |=> !pinVec[prevHit]); // R7

  AST_OTHER_WRITE_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtType == 2'd3 && streamId >= SID_W'(6)) |-> fillBypass); // R4

  AST_WRITEHIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtType == 2'd2) |=> (rrpvVec[2*prevHit +: 2] == 2'd0)); // R5

endmodule

bind rrip_pin_set rrip_pin_set_chk #(
  .WAYS(WAYS), .WAY_W(WAY_W), .SID_W(SID_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evtValid  (evtValid),
  .evtType   (evtType),
  .hitWay    (hitWay),
  .streamId  (streamId),
  .victimWay (victimWay),
  .fillBypass(fillBypass),
  .rrpvVec   (rrpvVec),
  .pinVec    (pinVec)
);

// File: tb/rrip_pin_set_test.sv
`timescale 1ns/1ps
module rrip_pin_set_test;

  localparam int WAYS = 4;
  localparam int NSTREAMS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evtValid = 1'b0;
  logic [1:0] evtType = 2'd0;
  logic [1:0] hitWay = 2'd0;
  logic [2:0] streamId = 3'd0;
  logic [7:0] wrHigh = 8'd0;
  logic       depthBypass = 1'b0;
  logic [1:0] rdBand = 2'd0;
  logic [1:0] victimWay;
  logic       fillBypass;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  rrip_pin_set #(.WAYS(WAYS), .NSTREAMS(NSTREAMS)) uut (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtType(evtType),
    .hitWay(hitWay), .streamId(streamId), .wrHigh(wrHigh),
    .depthBypass(depthBypass), .rdBand(rdBand),
    .victimWay(victimWay), .fillBypass(fillBypass)
  );

  typedef struct packed {
    logic [1:0] typ;
    logic [1:0] way;
    logic [2:0] sid;
    logic       wr;
    logic [1:0] band;
    logic       dby;
    logic       chkV;
    logic [1:0] expV;
    logic       expB;
    logic [3:0] req;
  } vec_t;

  // typ: 0 RH, 1 RM, 2 WH, 3 WM ; sid: 0 cpu 1 shader 2 color 3 depth 4 blit 5 tex 6 other
  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd0,1'b0,4'd2},  // R2 fill way0
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd1,1'b0,4'd2},  // R2
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd2,1'b0,4'd3},  // R3 prior fills at 2
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd3,1'b0,4'd3},  // R3
    '{2'd0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd0,1'b0,4'd7},  // R7 read hit w0
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd1,1'b0,4'd2},  // R2 aging
    '{2'd3,2'd0,3'd6,1'b0,2'd0,1'b0,1'b0,2'd0,1'b1,4'd4},  // R4 other write
    '{2'd3,2'd0,3'd3,1'b0,2'd0,1'b1,1'b0,2'd0,1'b1,4'd4},  // R4 depth bypass
    '{2'd3,2'd0,3'd3,1'b0,2'd0,1'b0,1'b1,2'd2,1'b0,4'd4},  // R4 depth alloc
    '{2'd3,2'd0,3'd2,1'b1,2'd0,1'b0,1'b1,2'd3,1'b0,4'd5},  // R5 color pinned fill
    '{2'd0,2'd2,3'd5,1'b0,2'd0,1'b0,1'b1,2'd1,1'b0,4'd8},  // R8 01->10
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd2,1'b0,4'd9},  // R9 band0 demoted
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd1,1'b0,4'd6},  // R6 w3 released
    '{2'd2,2'd0,3'd2,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,4'd5},  // R5 pin w0
    '{2'd2,2'd1,3'd2,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,4'd5},  // R5 pin w1
    '{2'd2,2'd2,3'd2,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,4'd5},  // R5 pin w2
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd3,1'b0,4'd6},  // R6 only w3 free
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd3,1'b0,4'd6},  // R6 releases left 0s
    '{2'd2,2'd0,3'd1,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,4'd5},  // R5
    '{2'd2,2'd1,3'd1,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,4'd5},  // R5
    '{2'd2,2'd2,3'd1,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,4'd5},  // R5
    '{2'd2,2'd3,3'd1,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,4'd5},  // R5 all pinned
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b0,2'd0,1'b1,4'd10}, // R10 read miss
    '{2'd3,2'd0,3'd1,1'b0,2'd0,1'b0,1'b0,2'd0,1'b1,4'd10}, // R10 write miss
    '{2'd0,2'd2,3'd0,1'b0,2'd0,1'b0,1'b0,2'd0,1'b0,4'd7},  // R7 unpin w2
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd2,1'b0,4'd7},  // R7 w2 now victim
    '{2'd0,2'd1,3'd5,1'b0,2'd1,1'b0,1'b1,2'd2,1'b0,4'd8},  // R8 band1 on w1
    '{2'd0,2'd1,3'd5,1'b0,2'd2,1'b0,1'b1,2'd1,1'b0,4'd9},  // R9 w1 at 2 after band1
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd2,1'b0,4'd9},  // R9 band2 gave 0
    '{2'd0,2'd2,3'd5,1'b0,2'd0,1'b0,1'b1,2'd2,1'b0,4'd9},  // R9 tex read on 00
    '{2'd1,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,2'd0,1'b0,4'd9}   // R9 w2 not demoted
  };

  task automatic checkOut(input logic chkV, input logic [1:0] expV,
                          input logic expB, input int req, input int idx);
    if (chkV) begin
      checks++;
      if (victimWay !== expV) begin
        failures++;
        $display("FAIL R%0d step %0d victimWay actual=%0d expected=%0d",
                 req, idx, victimWay, expV);
      end
    end
    checks++;
    if (fillBypass !== expB) begin
      failures++;
      $display("FAIL R%0d step %0d fillBypass actual=%0d expected=%0d",
               req, idx, fillBypass, expB);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic [1:0] w, input logic [2:0] s,
                       input logic wr, input logic [1:0] b, input logic d);
    @(negedge clk);
    evtValid    = 1'b1;
    evtType     = t;
    hitWay      = w;
    streamId    = s;
    wrHigh      = wr ? (8'd1 << s) : 8'd0;
    rdBand      = b;
    depthBypass = d;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle after reset
    checkOut(1'b1, 2'd0, 1'b0, 1, -1);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].typ, VECS[i].way, VECS[i].sid, VECS[i].wr, VECS[i].band, VECS[i].dby);
      checkOut(VECS[i].chkV, VECS[i].expV, VECS[i].expB, int'(VECS[i].req), i);
    end

    // R1: reset in the middle of a run restores the initial state
    @(negedge clk);
    evtValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(2'd1, 2'd0, 3'd0, 1'b0, 2'd0, 1'b0);
    checkOut(1'b1, 2'd0, 1'b0, 1, 100);

    // R4: blitter write miss allocated, stream 7 bypassed
    drive(2'd3, 2'd0, 3'd4, 1'b0, 2'd0, 1'b0);
    checkOut(1'b1, 2'd1, 1'b0, 4, 101);
    drive(2'd3, 2'd0, 3'd7, 1'b0, 2'd0, 1'b0);
    checkOut(1'b1, 2'd2, 1'b1, 4, 102);

    // R2: no event yet leaves victim unchanged at the lowest RRPV-3 way
    @(negedge clk);
    evtValid = 1'b0;
    #1;
    checkOut(1'b1, 2'd2, 1'b0, 2, 103);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule